// File: doc/BRIEF.md
# Double-Banked USB IN Endpoint Transmit Controller

This block holds the transmit side of one USB device IN endpoint with two payload banks. Firmware loads bytes into the bank that is currently open for filling and then arms it. The next bank to fill is then the other bank. The bus side answers each IN token from the bank whose turn it is. If that bank is not armed, it answers NAK. Otherwise it streams the bank's bytes and then waits for the host's handshake.

An ACK releases the bank, advances the send pointer and raises a transmit-complete flag, which also drives the interrupt. A timeout keeps the bank armed so that the next IN token sends it again. Because firmware can arm the second bank while the first is still queued or on the wire, back-to-back IN tokens can be served without a gap. The bus interface is abstract: a token pulse, a byte stream with an end-of-packet strobe, and ACK and timeout pulses. Line coding and CRC are handled elsewhere.

Top module: `usb_in_pingpong_ep`

## Requirements
- R1: A synchronous active-high reset leaves both banks unarmed, `tx_done`, `irq`, `arm_err`, `tx_valid`, `tx_eop` and `bus_nak` low, and both the fill and send pointers at bank 0.
- R2: While the fill bank is unarmed and holds fewer than DEPTH (64) bytes, each `fw_wr_en` cycle stores `fw_wr_data` at that bank's next byte position. Writes are dropped when the fill bank is armed, when the bank is already full, and in a cycle where `fw_arm` is high. `fw_arm` latches the number of bytes stored as the packet length, marks the bank armed and moves the fill pointer to the other bank.
- R3: Both banks may be armed at once. `bank_rdy[i]` is high while bank i is armed.
- R4: Packets are sent from the banks strictly in the order 0, 1, 0, 1, and so on.
- R5: An IN token that finds the send bank armed produces its bytes in order, one per cycle with `tx_valid` high, starting the cycle after the token. These are followed by one cycle of `tx_eop`. A zero-length bank produces only the `tx_eop` cycle.
- R6: An IN token that finds the send bank unarmed drives `bus_nak` high for exactly the next cycle, and no data or `tx_eop` is produced.
- R7: An ACK after `tx_eop` disarms the sent bank, advances the send pointer and sets `tx_done`. `irq` equals `tx_done`.
- R8: A timeout after `tx_eop` leaves the bank armed and the send pointer unchanged, so the next IN token sends the same bytes again.
- R9: `fw_clr_done` clears `tx_done`. If it coincides with an ACK, `tx_done` ends up set. If `tx_done` is already clear, it has no effect.
- R10: Arming a fill bank that is already armed changes no bank state and sets `arm_err`, which stays set until reset.
- R11: IN tokens that arrive while a packet is being sent or awaits its handshake are ignored. ACK and timeout pulses that arrive outside the handshake wait are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fw_wr_en | input | 1 | Store one byte into the fill bank |
| fw_wr_data | input | 8 | Byte to store |
| fw_arm | input | 1 | Arm the fill bank with the bytes stored so far |
| fw_clr_done | input | 1 | Clear the transmit-complete flag |
| bus_in_tok | input | 1 | IN token received (one-cycle pulse) |
| bus_ack | input | 1 | Host ACK received (one-cycle pulse) |
| bus_tmo | input | 1 | Handshake timeout (one-cycle pulse) |
| tx_valid | output | 1 | `tx_data` carries a payload byte |
| tx_data | output | 8 | Payload byte |
| tx_eop | output | 1 | End of the packet being sent |
| bus_nak | output | 1 | Answer NAK to the last token |
| bank_rdy | output | 2 | Armed flag per bank |
| tx_done | output | 1 | Transmit-complete flag |
| irq | output | 1 | Interrupt request |
| arm_err | output | 1 | Sticky error: arm of an armed bank |

## Verification
The assertions assume that the bus side raises ACK or timeout only after it has seen `tx_eop`, and never both in one cycle. They also assume that firmware writes and arms through the ports one operation per cycle. The bench drives each bus pulse only after it has observed the end-of-packet strobe, and it issues writes, arms and clears one at a time. The one deliberate exception is a clear in the same cycle as an ACK, which exercises the set-wins rule. The bench also sends a redundant token during a transfer and an ACK while idle, to show that both are ignored.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SEND = 2'd1,
        TX_WAIT = 2'd2
    } tx_state_e;
endpackage

// File: rtl/ep_bank_store.sv
module ep_bank_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          wr_bank,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_bank,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem_q [2][DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[wr_bank][wr_addr] <= wr_data;
    end

    always_comb rd_data = mem_q[rd_bank][rd_addr];
endmodule

// File: rtl/ep_fill_ctrl.sv
module ep_fill_ctrl #(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1),
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fw_wr_en,
    input  logic                fw_arm,
    input  logic                rel_en,
    input  logic                rel_bank,
    output logic                we,
    output logic                wr_bank,
    output logic [AW-1:0]       wr_addr,
    output logic [1:0]          rdy,
    output logic [1:0][CW-1:0]  cnt,
    output logic                arm_err
);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    typedef struct packed {
        logic               fill;
        logic [CW-1:0]      widx;
        logic [1:0]         rdy;
        logic [1:0][CW-1:0] cnt;
        logic               err;
    } fill_st_t;

    fill_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        we   = 1'b0;
        if (rel_en) st_d.rdy[rel_bank] = 1'b0;
        if (fw_arm) begin
            if (st_q.rdy[st_q.fill]) begin
                st_d.err = 1'b1;
            end else begin
                st_d.rdy[st_q.fill] = 1'b1;
                st_d.cnt[st_q.fill] = st_q.widx;
                st_d.widx           = '0;
                st_d.fill           = ~st_q.fill;
            end
        end else if (fw_wr_en && !st_q.rdy[st_q.fill] && (st_q.widx < FULL_C)) begin
            we        = 1'b1;
            st_d.widx = st_q.widx + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign wr_bank = st_q.fill;
    assign wr_addr = st_q.widx[AW-1:0];
    assign rdy     = st_q.rdy;
    assign cnt     = st_q.cnt;
    assign arm_err = st_q.err;

    p_arm_moves_fill_r2: assert property (@(posedge clk) disable iff (rst)
        (fw_arm && !st_q.rdy[st_q.fill]) |=> (st_q.fill != $past(st_q.fill)));
    p_len_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt[0] <= FULL_C) && (st_q.cnt[1] <= FULL_C));
    p_rearm_err_r10: assert property (@(posedge clk) disable iff (rst)
        (fw_arm && st_q.rdy[st_q.fill]) |=> (arm_err && $stable(st_q.fill)));
endmodule

// File: rtl/ep_tx_ctrl.sv
module ep_tx_ctrl
    import usb_in_ep_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1),
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_in_tok,
    input  logic               bus_ack,
    input  logic               bus_tmo,
    input  logic               fw_clr_done,
    input  logic [1:0]         rdy,
    input  logic [1:0][CW-1:0] cnt,
    output logic               rd_bank,
    output logic [AW-1:0]      rd_addr,
    output logic               tx_valid,
    output logic               tx_eop,
    output logic               bus_nak,
    output logic               rel_en,
    output logic               rel_bank,
    output logic               tx_done
);
    typedef struct packed {
        tx_state_e     state;
        logic          snd;
        logic [CW-1:0] idx;
        logic [CW-1:0] len;
        logic          nak;
        logic          done;
    } tx_st_t;

    tx_st_t st_d, st_q;
    logic   at_end;

    always_comb begin
        st_d     = st_q;
        st_d.nak = 1'b0;
        rel_en   = 1'b0;
        at_end   = (st_q.idx == st_q.len);
        if (fw_clr_done) st_d.done = 1'b0;
        case (st_q.state)
            TX_IDLE: begin
                if (bus_in_tok) begin
                    if (rdy[st_q.snd]) begin
                        st_d.state = TX_SEND;
                        st_d.idx   = '0;
                        st_d.len   = cnt[st_q.snd];
                    end else begin
                        st_d.nak = 1'b1;
                    end
                end
            end
            TX_SEND: begin
                if (at_end) st_d.state = TX_WAIT;
                else        st_d.idx   = st_q.idx + CW'(1);
            end
            TX_WAIT: begin
                if (bus_ack) begin
                    rel_en     = 1'b1;
                    st_d.snd   = ~st_q.snd;
                    st_d.done  = 1'b1;
                    st_d.state = TX_IDLE;
                end else if (bus_tmo) begin
                    st_d.state = TX_IDLE;
                end
            end
            default: st_d.state = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign tx_valid = (st_q.state == TX_SEND) && (st_q.idx != st_q.len);
    assign tx_eop   = (st_q.state == TX_SEND) && (st_q.idx == st_q.len);
    assign rd_bank  = st_q.snd;
    assign rd_addr  = st_q.idx[AW-1:0];
    assign rel_bank = st_q.snd;
    assign bus_nak  = st_q.nak;
    assign tx_done  = st_q.done;

    p_send_from_armed_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q.state == TX_SEND) |-> rdy[st_q.snd]);
    p_nak_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q.state == TX_IDLE && bus_in_tok && !rdy[st_q.snd]) |=> (bus_nak && !tx_valid && !tx_eop));
    p_ack_advances_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q.state == TX_WAIT && bus_ack) |=> (tx_done && st_q.snd != $past(st_q.snd)));
    p_tmo_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q.state == TX_WAIT && bus_tmo && !bus_ack) |=> ($stable(st_q.snd) && rdy[st_q.snd]));
    p_clear_done_r9: assert property (@(posedge clk) disable iff (rst)
        (fw_clr_done && !(st_q.state == TX_WAIT && bus_ack)) |=> !tx_done);
endmodule

// File: rtl/usb_in_pingpong_ep.sv
module usb_in_pingpong_ep #(
    parameter int DW    = 8,
    parameter int DEPTH = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fw_wr_en,
    input  logic [DW-1:0] fw_wr_data,
    input  logic          fw_arm,
    input  logic          fw_clr_done,
    input  logic          bus_in_tok,
    input  logic          bus_ack,
    input  logic          bus_tmo,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data,
    output logic          tx_eop,
    output logic          bus_nak,
    output logic [1:0]    bank_rdy,
    output logic          tx_done,
    output logic          irq,
    output logic          arm_err
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int AW = $clog2(DEPTH);

    logic               we, wr_bank, rd_bank, rel_en, rel_bank;
    logic [AW-1:0]      wr_addr, rd_addr;
    logic [1:0]         rdy;
    logic [1:0][CW-1:0] cnt;

    ep_fill_ctrl #(.DEPTH(DEPTH), .CW(CW), .AW(AW)) u_fill (
        .clk(clk), .rst(rst), .fw_wr_en(fw_wr_en), .fw_arm(fw_arm),
        .rel_en(rel_en), .rel_bank(rel_bank), .we(we), .wr_bank(wr_bank),
        .wr_addr(wr_addr), .rdy(rdy), .cnt(cnt), .arm_err(arm_err)
    );

    ep_bank_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk(clk), .we(we), .wr_bank(wr_bank), .wr_addr(wr_addr),
        .wr_data(fw_wr_data), .rd_bank(rd_bank), .rd_addr(rd_addr),
        .rd_data(tx_data)
    );

    ep_tx_ctrl #(.DEPTH(DEPTH), .CW(CW), .AW(AW)) u_tx (
        .clk(clk), .rst(rst), .bus_in_tok(bus_in_tok), .bus_ack(bus_ack),
        .bus_tmo(bus_tmo), .fw_clr_done(fw_clr_done), .rdy(rdy), .cnt(cnt),
        .rd_bank(rd_bank), .rd_addr(rd_addr), .tx_valid(tx_valid),
        .tx_eop(tx_eop), .bus_nak(bus_nak), .rel_en(rel_en),
        .rel_bank(rel_bank), .tx_done(tx_done)
    );

    assign bank_rdy = rdy;
    assign irq      = tx_done;

    p_irq_follows_done_r7: assert property (@(posedge clk) disable iff (rst)
        irq == tx_done);
    p_one_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        !(tx_valid && tx_eop));
endmodule

// File: tb/sim_usb_in_pingpong_ep.sv
`timescale 1ns/1ps
module sim_usb_in_pingpong_ep;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fw_wr_en = 1'b0, fw_arm = 1'b0, fw_clr_done = 1'b0;
    logic [7:0] fw_wr_data = 8'd0;
    logic       bus_in_tok = 1'b0, bus_ack = 1'b0, bus_tmo = 1'b0;
    logic       tx_valid, tx_eop, bus_nak, tx_done, irq, arm_err;
    logic [7:0] tx_data;
    logic [1:0] bank_rdy;

    int n_chk = 0, n_bad = 0;
    int exp_q[$];
    int bank_m[2][$];
    logic [1:0] rdy_m = 2'b00;
    logic fill_m = 1'b0, snd_m = 1'b0, done_m = 1'b0, err_m = 1'b0;

    always #2 clk = ~clk;

    usb_in_pingpong_ep u0 (
        .clk(clk), .rst(rst), .fw_wr_en(fw_wr_en), .fw_wr_data(fw_wr_data),
        .fw_arm(fw_arm), .fw_clr_done(fw_clr_done), .bus_in_tok(bus_in_tok),
        .bus_ack(bus_ack), .bus_tmo(bus_tmo), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_eop(tx_eop), .bus_nak(bus_nak),
        .bank_rdy(bank_rdy), .tx_done(tx_done), .irq(irq), .arm_err(arm_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // monitor: pops expected bytes (256 marks end of packet)
    always @(negedge clk) begin
        if (!rst && (tx_valid || tx_eop)) begin
            int got;
            got = tx_eop ? 256 : int'(tx_data);
            if (exp_q.size() == 0) chk("R5/R11 unexpected output", got, -1);
            else chk("R4/R5 stream", got, exp_q.pop_front());
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    task automatic cyc(); @(negedge clk); endtask

    task automatic wr(input int b);
        fw_wr_en = 1'b1; fw_wr_data = 8'(b); cyc(); fw_wr_en = 1'b0;
        if (!rdy_m[fill_m] && bank_m[fill_m].size() < 64) bank_m[fill_m].push_back(b & 255);
    endtask

    task automatic arm();
        fw_arm = 1'b1; cyc(); fw_arm = 1'b0;
        if (rdy_m[fill_m]) err_m = 1'b1;
        else begin rdy_m[fill_m] = 1'b1; fill_m = ~fill_m; end
    endtask

    task automatic clr();
        fw_clr_done = 1'b1; cyc(); fw_clr_done = 1'b0; done_m = 1'b0;
    endtask

    // driver: push expected packet, issue token, wait for end of packet
    task automatic send(input bit extra_tok);
        foreach (bank_m[snd_m][i]) exp_q.push_back(bank_m[snd_m][i]);
        exp_q.push_back(256);
        bus_in_tok = 1'b1; cyc();
        if (extra_tok) cyc();   // R11: token during transfer
        bus_in_tok = 1'b0;
        for (int k = 0; k < 200 && !tx_eop; k++) cyc();
        chk("R5 end of packet seen", int'(tx_eop), 1);
    endtask

    task automatic ack(input bit with_clr);
        cyc();
        bus_ack = 1'b1; fw_clr_done = with_clr; cyc();
        bus_ack = 1'b0; fw_clr_done = 1'b0;
        rdy_m[snd_m] = 1'b0; bank_m[snd_m].delete(); snd_m = ~snd_m; done_m = 1'b1;
        chk("R7 tx_done after ack", int'(tx_done), int'(done_m));
        chk("R7 irq after ack", int'(irq), 1);
        chk("R7 bank_rdy after ack", int'(bank_rdy), int'(rdy_m));
    endtask

    task automatic tmo();
        cyc(); bus_tmo = 1'b1; cyc(); bus_tmo = 1'b0;
        chk("R8 bank still armed", int'(bank_rdy), int'(rdy_m));
        chk("R8 no done", int'(tx_done), 0);
    endtask

    task automatic nak_test(input string req);
        bus_in_tok = 1'b1; cyc(); bus_in_tok = 1'b0;
        chk({req, " nak pulse"}, int'(bus_nak), 1);
        cyc();
        chk({req, " nak one cycle"}, int'(bus_nak), 0);
    endtask

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        // R1 reset state
        chk("R1 bank_rdy", int'(bank_rdy), 0);
        chk("R1 tx_done", int'(tx_done), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 arm_err", int'(arm_err), 0);
        chk("R1 tx_valid/eop/nak", int'({tx_valid, tx_eop, bus_nak}), 0);

        nak_test("R6");

        // R11 ack while idle ignored
        bus_ack = 1'b1; cyc(); bus_ack = 1'b0;
        chk("R11 stray ack done", int'(tx_done), 0);
        chk("R11 stray ack rdy", int'(bank_rdy), 0);

        // R2/R3 fill both banks
        for (int i = 0; i < 3; i++) wr(10 + i);
        arm();
        for (int i = 0; i < 5; i++) wr(20 + i);
        arm();
        chk("R3 both armed", int'(bank_rdy), 3);

        // R10 rearm armed bank, R2 write to armed bank dropped
        arm();
        wr(99);
        chk("R10 arm_err", int'(arm_err), 1);
        chk("R10 rdy unchanged", int'(bank_rdy), 3);

        // R8 timeout then resend, R7 ack
        send(1'b0);
        tmo();
        send(1'b0);
        ack(1'b0);

        // R2 zero-length bank 0, R9 clears
        arm();
        chk("R2 zero-length armed", int'(bank_rdy), 3);
        clr();
        chk("R9 clear", int'(tx_done), 0);
        clr();
        chk("R9 clear when clear", int'(tx_done), 0);

        // R4 bank 1 next, R11 extra token, R9 clear with ack
        send(1'b1);
        ack(1'b1);
        chk("R9 set wins", int'(tx_done), 1);

        // R5 zero-length packet from bank 0
        send(1'b0);
        ack(1'b0);
        chk("R7 all released", int'(bank_rdy), 0);

        // R2 cap at 64 bytes in bank 1
        for (int i = 0; i < 70; i++) wr(100 + i);
        arm();
        send(1'b0);
        ack(1'b0);

        nak_test("R6 after drain");
        chk("R10 err sticky", int'(arm_err), int'(err_m));
        chk("R5 all expected seen", exp_q.size(), 0);
        summary();
    end
endmodule